// File: doc/BRIEF.md
# Sample Fetch Sequencer with Completion Interrupt

This block feeds a delta-modulation audio channel with sample bytes read from memory. Software programs a control register (rate and end-of-sample mode), a start register and a length register, then sets the enable bit in the status register. While the channel is active, a programmable down-counter paces the fetches. Each fetch raises a one-cycle bus-stall request, presents a 16-bit address, and passes the returned byte to the output unit through a one-cycle strobe.

The start address is formed as 0xC000 plus the start register shifted left by six. The length counter is loaded with the length register shifted left by four, so one playback covers (length × 16) + 1 bytes. Fetch addresses advance by one and wrap from 0xFFFF back to 0x8000. At the end of a playback the mode field picks one of three actions: stop quietly, reload and loop, or stop and raise an interrupt flag. The flag stays set until software acknowledges it.

Top module: `sample_fetch`

## Requirements
- R1: The fetch period is N clocks, where N is the 12-bit entry of the rate table selected by control bits 3:0. The first fetch occurs N-1 cycles after the cycle in which the enabling status write is taken. Later fetches follow every N cycles.
- R2: The first fetch address after a start is 0xC000 + (start register << 6). Each later fetch in the same playback uses the previous address plus one.
- R3: A fetch address of 0xFFFF is followed by 0x8000, so bit 15 of every fetch address is 1.
- R4: With control bits 7:6 = 00, a playback performs exactly (length register × 16) + 1 fetches and then goes inactive without setting the interrupt flag.
- R5: With control bit 6 = 1 (loop), the address and length counters reload from the registers when the count is done, and fetching continues at the same period.
- R6: With control bits 7:6 = 10, the interrupt flag is set at the last fetch of the playback and the channel goes inactive. The flag is never set except at a fetch.
- R7: The interrupt flag clears on any write to the status register, or on a control write with bit 7 = 0. A status read, or a control write with bit 7 = 1, leaves it set.
- R8: Register select codes are 0 control, 1 start, 2 length and 3 status. A status read returns the interrupt flag in bit 7, the active bit in bit 4 and zeros elsewhere. A read of any other select code returns 0x40.
- R9: Writing status bit 4 = 1 while the channel is active changes neither the timing nor the addresses. Writing status bit 4 = 0 makes the channel inactive, and no further fetch follows.
- R10: Every fetch holds mem_req high for exactly one cycle. byte_valid is high in that same cycle, with byte_data equal to mem_rdata.
- R11: After reset the channel is inactive, the interrupt flag is clear, no fetch is requested, and a status read returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select for both reads and writes |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational on reg_sel) |
| irq | output | 1 | Interrupt flag |
| mem_req | output | 1 | One-cycle fetch and CPU stall request |
| mem_addr | output | 16 | Fetch address |
| mem_rdata | input | 8 | Memory data, valid in the same cycle as mem_req |
| byte_valid | output | 1 | Sample byte strobe toward the output unit |
| byte_data | output | 8 | Sample byte toward the output unit |

## Verification
A wrong period counter shows up at the first fetch, as a mem_req pulse landing one or more cycles off the expected slot. An address counter that is wrong, or that misses the wrap, shows on mem_addr at the fetch where it goes astray. This is most visible at the 0xFFFF boundary. A length counter that is off by one changes the number of fetches and moves the fall of the status active bit by one full period. It also moves the interrupt flag to a different cycle. Any error in the acknowledge logic is seen on irq in the cycle right after the offending register write.

// File: rtl/sample_fetch_pkg.sv
package sample_fetch_pkg;

    localparam int RATE_W  = 12;
    localparam int LEN_W   = 12;
    localparam int ADDR_W  = 16;
    localparam int SEL_W   = 3;
    localparam int N_RATES = 16;

    typedef logic [N_RATES-1:0][RATE_W-1:0] rate_table_t;

    // entry 0 is the slowest rate, entry 15 the fastest
    localparam rate_table_t DEFAULT_RATES = {
        12'd54,  12'd72,  12'd85,  12'd106, 12'd128, 12'd142, 12'd160, 12'd190,
        12'd214, 12'd226, 12'd254, 12'd286, 12'd320, 12'd340, 12'd380, 12'd428
    };

    typedef enum logic [SEL_W-1:0] {
        SEL_CTRL   = 3'd0,
        SEL_START  = 3'd1,
        SEL_LEN    = 3'd2,
        SEL_STATUS = 3'd3
    } reg_sel_e;

    typedef struct packed {
        logic [1:0] mode;      // bit 1: raise interrupt, bit 0: loop
        logic [1:0] spare;
        logic [3:0] rate_idx;
    } ctrl_t;

    typedef struct packed {
        ctrl_t      ctrl;
        logic [7:0] start;
        logic [7:0] len;
    } cfg_t;

    typedef struct packed {
        logic start_req;   // enable bit written as 1
        logic stop_req;    // enable bit written as 0
        logic irq_ack;     // acknowledge of the interrupt flag
    } cmd_t;

    localparam logic [7:0] OPEN_BUS = 8'h40;

    function automatic logic [ADDR_W-1:0] first_addr(input logic [7:0] start);
        return 16'hC000 + {2'b00, start, 6'b000000};
    endfunction

    function automatic logic [ADDR_W-1:0] step_addr(input logic [ADDR_W-1:0] a);
        return {1'b1, a[ADDR_W-2:0] + 15'd1};
    endfunction

    function automatic logic [LEN_W-1:0] first_len(input logic [7:0] len);
        return {len, 4'b0000};
    endfunction

endpackage

// File: rtl/sample_fetch_regs.sv
module sample_fetch_regs
    import sample_fetch_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_wr,
    input  logic [SEL_W-1:0] reg_sel,
    input  logic [7:0]       reg_wdata,
    input  logic             active,
    input  logic             irq_flag,
    output cfg_t             cfg,
    output cmd_t             cmd,
    output logic [7:0]       reg_rdata
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (reg_wr) begin
            case (reg_sel)
                SEL_CTRL:  cfg.ctrl  <= ctrl_t'(reg_wdata);
                SEL_START: cfg.start <= reg_wdata;
                SEL_LEN:   cfg.len   <= reg_wdata;
                default:   ;
            endcase
        end
    end

    always_comb begin
        cmd = '0;
        if (reg_wr && reg_sel == SEL_STATUS) begin
            cmd.start_req = reg_wdata[4];
            cmd.stop_req  = ~reg_wdata[4];
            cmd.irq_ack   = 1'b1;
        end
        if (reg_wr && reg_sel == SEL_CTRL && !reg_wdata[7]) begin
            cmd.irq_ack = 1'b1;
        end
    end

    always_comb begin
        if (reg_sel == SEL_STATUS) begin
            reg_rdata = {irq_flag, 2'b00, active, 4'b0000};
        end else begin
            reg_rdata = OPEN_BUS;
        end
    end

endmodule

// File: rtl/sample_fetch_timer.sv
module sample_fetch_timer
    import sample_fetch_pkg::*;
#(
    parameter rate_table_t RATES = DEFAULT_RATES
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  logic       active,
    input  logic [3:0] rate_idx,
    output logic       tick
);

    logic [RATE_W-1:0] cnt;
    logic [RATE_W-1:0] reload;

    assign reload = RATES[rate_idx] - RATE_W'(1);
    assign tick   = active && (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= reload;
        end else if (active) begin
            if (cnt == '0) begin
                cnt <= reload;
            end else begin
                cnt <= cnt - RATE_W'(1);
            end
        end
    end

endmodule

// File: rtl/sample_fetch_seq.sv
module sample_fetch_seq
    import sample_fetch_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  cfg_t              cfg,
    input  cmd_t              cmd,
    input  logic              tick,
    output logic              active,
    output logic              irq_flag,
    output logic              start_now,
    output logic [ADDR_W-1:0] addr
);

    logic [LEN_W-1:0] remain;
    logic             last;
    logic             loop_mode;
    logic             irq_mode;

    assign start_now = cmd.start_req && !active;
    assign last      = tick && (remain == '0);
    assign loop_mode = cfg.ctrl.mode[0];
    assign irq_mode  = (cfg.ctrl.mode == 2'b10);

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            addr   <= 16'hC000;
            remain <= '0;
        end else if (cmd.stop_req) begin
            active <= 1'b0;
        end else if (start_now) begin
            active <= 1'b1;
            addr   <= first_addr(cfg.start);
            remain <= first_len(cfg.len);
        end else if (tick) begin
            if (last) begin
                if (loop_mode) begin
                    addr   <= first_addr(cfg.start);
                    remain <= first_len(cfg.len);
                end else begin
                    active <= 1'b0;
                end
            end else begin
                addr   <= step_addr(addr);
                remain <= remain - LEN_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_flag <= 1'b0;
        end else if (cmd.irq_ack) begin
            irq_flag <= 1'b0;
        end else if (last && !loop_mode && irq_mode) begin
            irq_flag <= 1'b1;
        end
    end

endmodule

// File: rtl/sample_fetch.sv
module sample_fetch
    import sample_fetch_pkg::*;
#(
    parameter rate_table_t RATES = DEFAULT_RATES
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_wr,
    input  logic [SEL_W-1:0] reg_sel,
    input  logic [7:0]       reg_wdata,
    output logic [7:0]       reg_rdata,
    output logic             irq,
    output logic             mem_req,
    output logic [15:0]      mem_addr,
    input  logic [7:0]       mem_rdata,
    output logic             byte_valid,
    output logic [7:0]       byte_data
);

    cfg_t              cfg;
    cmd_t              cmd;
    logic              chan_active;
    logic              irq_flag;
    logic              start_now;
    logic              tick;
    logic [ADDR_W-1:0] addr;

    sample_fetch_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .active    (chan_active),
        .irq_flag  (irq_flag),
        .cfg       (cfg),
        .cmd       (cmd),
        .reg_rdata (reg_rdata)
    );

    sample_fetch_timer #(.RATES(RATES)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (start_now),
        .active   (chan_active),
        .rate_idx (cfg.ctrl.rate_idx),
        .tick     (tick)
    );

    sample_fetch_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .cfg       (cfg),
        .cmd       (cmd),
        .tick      (tick),
        .active    (chan_active),
        .irq_flag  (irq_flag),
        .start_now (start_now),
        .addr      (addr)
    );

    assign irq        = irq_flag;
    assign mem_req    = tick;
    assign mem_addr   = addr;
    assign byte_valid = tick;
    assign byte_data  = mem_rdata;

endmodule

// File: rtl/sample_fetch_chk.sv
module sample_fetch_chk (
    input logic        clk,
    input logic        rst,
    input logic        reg_wr,
    input logic [2:0]  reg_sel,
    input logic        irq,
    input logic        mem_req,
    input logic [15:0] mem_addr,
    input logic        byte_valid,
    input logic        active
);

    a_r10_single_stall: assert property (@(posedge clk) disable iff (rst)
        mem_req |=> !mem_req);

    a_r10_strobe_aligned: assert property (@(posedge clk) disable iff (rst)
        byte_valid == mem_req);

    a_r3_upper_half: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> mem_addr[15]);

    a_r7_status_ack: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_sel == 3'd3) |=> !irq);

    a_r6_irq_at_fetch: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(mem_req));

    a_r9_idle_no_fetch: assert property (@(posedge clk) disable iff (rst)
        !active |-> !mem_req);

    a_r11_reset_clear: assert property (@(posedge clk)
        rst |=> (!irq && !active));

endmodule

bind sample_fetch sample_fetch_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .reg_wr     (reg_wr),
    .reg_sel    (reg_sel),
    .irq        (irq),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .byte_valid (byte_valid),
    .active     (chan_active)
);

// File: tb/sim_sample_fetch.sv
`timescale 1ns/1ps
module sim_sample_fetch;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_sel = 3'd0;
    logic [7:0]  reg_wdata = 8'd0;
    logic [7:0]  reg_rdata;
    logic        irq;
    logic        mem_req;
    logic [15:0] mem_addr;
    logic [7:0]  mem_rdata;
    logic        byte_valid;
    logic [7:0]  byte_data;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    int nf = 0;
    logic [15:0] fa [0:127];
    int          fc [0:127];

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    assign mem_rdata = mem_addr[7:0] ^ mem_addr[15:8] ^ 8'h5A;

    sample_fetch u0 (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .byte_valid(byte_valid), .byte_data(byte_data)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int rate_of(input int idx);
        case (idx)
            0: return 428;  1: return 380;  2: return 340;  3: return 320;
            4: return 286;  5: return 254;  6: return 226;  7: return 214;
            8: return 190;  9: return 160; 10: return 142; 11: return 128;
            12: return 106; 13: return 85; 14: return 72;  default: return 54;
        endcase
    endfunction

    function automatic logic [15:0] exp_first(input logic [7:0] a);
        return 16'hC000 + {2'b00, a, 6'b0};
    endfunction

    function automatic logic [15:0] exp_next(input logic [15:0] x);
        return {1'b1, x[14:0] + 15'd1};
    endfunction

    // fetch monitor, R10 checked on every fetch
    always @(negedge clk) begin
        if (!rst && mem_req) begin
            if (nf < 128) begin
                fa[nf] = mem_addr;
                fc[nf] = cyc;
            end
            nf++;
            chk(byte_valid && byte_data == mem_rdata, "R10 strobe/data",
                {byte_valid, byte_data}, {1'b1, mem_rdata});
        end
    end

    task automatic wr(input logic [2:0] sel, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] sel, output logic [7:0] v);
        @(negedge clk);
        reg_sel = sel;
        #1;
        v = reg_rdata;
    endtask

    task automatic wait_until(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    task automatic start_run(input logic [7:0] ctrl, input logic [7:0] a,
                             input logic [7:0] l, output int c0);
        wr(3'd0, ctrl);
        wr(3'd1, a);
        wr(3'd2, l);
        nf = 0;
        wr(3'd3, 8'h10);
        c0 = cyc;
    endtask

    // R1, R2, R3, R4: count, addresses and timing of a finished non-loop run
    task automatic check_run(input int idx, input logic [7:0] a, input logic [7:0] l,
                             input int c0, input bit irq_exp);
        int n = rate_of(idx);
        int total = l * 16 + 1;
        logic [15:0] ea = exp_first(a);
        logic [7:0] v;
        wait_until(c0 + total * n + 5);
        chk(nf == total, "R4 fetch count", nf, total);
        for (int j = 0; j < total && j < 128; j++) begin
            chk(fa[j] == ea, (j == 0) ? "R2 first address" : "R3 address step", fa[j], ea);
            chk(fc[j] == c0 + n - 1 + j * n, "R1 fetch timing", fc[j] - c0, n - 1 + j * n);
            ea = exp_next(ea);
        end
        rd(3'd3, v);
        chk(v[4] == 1'b0, "R4 inactive at end", v, 8'h00);
        chk(irq == irq_exp, "R6 irq at end", irq, irq_exp);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=%0h expected=%0h", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [7:0] v;
        int c0;
        int held;
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R11 reset state
        rd(3'd3, v);
        chk(v == 8'h00, "R11 status after reset", v, 8'h00);
        chk(!irq && !mem_req, "R11 irq/req after reset", {irq, mem_req}, 0);

        // R8 open-bus reads
        rd(3'd0, v); chk(v == 8'h40, "R8 control read", v, 8'h40);
        rd(3'd1, v); chk(v == 8'h40, "R8 start read", v, 8'h40);
        rd(3'd2, v); chk(v == 8'h40, "R8 length read", v, 8'h40);
        rd(3'd6, v); chk(v == 8'h40, "R8 unmapped read", v, 8'h40);

        // directed: fastest rate, one byte
        start_run(8'h0F, 8'h00, 8'h00, c0);
        rd(3'd3, v);
        chk(v == 8'h10, "R8 status active", v, 8'h10);
        check_run(15, 8'h00, 8'h00, c0, 1'b0);

        // R3 wrap: FFC0 start, 65 bytes cross FFFF -> 8000
        start_run(8'h0F, 8'hFF, 8'h04, c0);
        check_run(15, 8'hFF, 8'h04, c0, 1'b0);
        chk(fa[64] == 16'h8000, "R3 wrap to 8000", fa[64], 16'h8000);

        // random runs, mode 00
        for (int k = 0; k < 4; k++) begin
            int idx = int'($urandom % 16);
            logic [7:0] a = 8'($urandom);
            logic [7:0] l = 8'($urandom % 2);
            start_run({4'b0000, 4'(idx)}, a, l, c0);
            check_run(idx, a, l, c0, 1'b0);
        end

        // R9: re-enable while active has no effect
        start_run(8'h0F, 8'h22, 8'h01, c0);
        wait_until(c0 + 100);
        wr(3'd3, 8'h10);
        check_run(15, 8'h22, 8'h01, c0, 1'b0);

        // R9: disable mid-run stops fetching
        start_run(8'h0F, 8'h33, 8'h01, c0);
        wait_until(c0 + 5 * 54);
        wr(3'd3, 8'h00);
        rd(3'd3, v);
        chk(v[4] == 1'b0, "R9 disable clears active", v, 8'h00);
        held = nf;
        repeat (200) @(negedge clk);
        chk(nf == held, "R9 no fetch after disable", nf, held);

        // R5 loop mode
        start_run(8'h4F, 8'h10, 8'h00, c0);
        wait_until(c0 + 53 + 3 * 54 + 5);
        chk(nf == 4, "R5 loop fetch count", nf, 4);
        for (int j = 0; j < 4; j++) begin
            chk(fa[j] == 16'hC400, "R5 loop reload address", fa[j], 16'hC400);
            chk(fc[j] == c0 + 53 + j * 54, "R5 loop timing", fc[j] - c0, 53 + j * 54);
        end
        rd(3'd3, v);
        chk(v == 8'h10, "R5 still active", v, 8'h10);
        wr(3'd3, 8'h00);
        held = nf;
        repeat (120) @(negedge clk);
        chk(nf == held, "R9 loop stopped", nf, held);

        // R6 interrupt mode and R7 acknowledge paths
        start_run(8'h8F, 8'h05, 8'h00, c0);
        check_run(15, 8'h05, 8'h00, c0, 1'b1);
        rd(3'd3, v);
        chk(v == 8'h80, "R8 status irq bit", v, 8'h80);
        rd(3'd3, v);
        chk(irq == 1'b1, "R7 read does not clear", irq, 1);
        wr(3'd0, 8'hCF);
        chk(irq == 1'b1, "R7 control bit7=1 keeps", irq, 1);
        wr(3'd0, 8'h0F);
        chk(irq == 1'b0, "R7 control bit7=0 clears", irq, 0);

        start_run(8'h8F, 8'h05, 8'h00, c0);
        check_run(15, 8'h05, 8'h00, c0, 1'b1);
        wr(3'd3, 8'h00);
        chk(irq == 1'b0, "R7 status write clears", irq, 0);
        rd(3'd3, v);
        chk(v == 8'h00, "R7 status after ack", v, 8'h00);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule